// File: doc/BRIEF.md
# Sector Hamming ECC Checker

This block computes a 24-bit single-error-correcting parity code over a sector of bytes that arrives as a stream. Each accepted byte has a byte offset, and each of its data bits has a 12-bit position made of that offset followed by the bit index. Every set data bit toggles one parity half or the other for each of the twelve position bits. When the code is written out it goes to storage. On a read, the block compares the freshly computed code with the stored code that the caller supplies. It reports one of four outcomes: a clean sector, a single data bit to flip (with byte offset and bit index), a fault confined to the stored code, or an uncorrectable sector. The code is inverted before output, so an erased sector of all-ones bytes has an all-ones code and checks clean against erased spare bytes.

A sector begins with a one-cycle `sector_start` pulse. A byte presented in that same cycle is byte 0. The mode (generate or check) is taken at the start pulse. The control state machine has three states. IDLE waits and ignores bytes. GATHER counts accepted bytes. REPORT lasts exactly one cycle and drives `done` together with the result. The transitions are: IDLE to GATHER on a start pulse, GATHER to GATHER on a start pulse (restart), GATHER to REPORT when the last byte is accepted, REPORT to GATHER on a start pulse, and REPORT to IDLE otherwise. Applying the fix to the sector buffer is left to the caller.

Top module: `sector_ecc_core`

## Requirements
- R1: The 24-bit code is the bitwise inverse of {P, Q}, where bit k of the upper half P (code bits 23:12) is the XOR of every data bit whose 12-bit position {byte offset, bit index} has bit k set, and bit k of Q (bits 11:0) covers positions with bit k clear. Code byte 0 is bits 7:0, stored first. After reset `code_out` reads 24'hFFFFFF.
- R2: A sector of all 8'hFF bytes yields code 24'hFFFFFF and, checked against a stored 24'hFFFFFF, reports status 0.
- R3: `done` is high for exactly one cycle, the cycle after the SECTOR_BYTES-th byte is accepted, and `code_out` is valid then. While `done` is low, `status`, `err_offset` and `err_bit` are zero.
- R4: `sector_start` clears the parity and the byte count. A byte valid in the same cycle is byte 0. A start in mid-sector discards the partial sector.
- R5: Bytes with `byte_valid` low, and bytes offered in IDLE without a start, are ignored. `code_out` holds its last value while IDLE.
- R6: In check mode (`check_mode` high at the start pulse), a zero difference between `stored_code` and the computed code gives status 0 (clean).
- R7: If the upper and lower 12 bits of the difference XOR to all ones, status is 1 (data fix), `err_offset` is difference bits 23:15 and `err_bit` is bits 14:12. Both fields are zero for any other status.
- R8: A data-fix pattern whose byte offset is SECTOR_BYTES or more gives status 3.
- R9: A difference with exactly one bit set gives status 2 (code fault, data intact).
- R10: Any other nonzero difference gives status 3 (uncorrectable).
- R11: In generate mode (`check_mode` low at the start pulse), status is 0 whatever `stored_code` holds.
- R12: A start pulse and byte in the REPORT cycle begin the next sector. The report in that cycle still belongs to the finished sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_start | input | 1 | One-cycle pulse opening a sector |
| byte_valid | input | 1 | Byte on `byte_data` is offered this cycle |
| byte_data | input | 8 | Sector byte |
| check_mode | input | 1 | 1 = check against stored code, 0 = generate; taken at start |
| stored_code | input | 24 | Code read back from storage; looked at while `done` is high |
| code_out | output | 24 | Computed (inverted) code |
| done | output | 1 | Result valid this cycle |
| status | output | 2 | 0 clean, 1 data fix, 2 code fault, 3 uncorrectable |
| err_offset | output | 9 | Byte offset of the bit to flip |
| err_bit | output | 3 | Bit index within that byte |

## Verification
The report of a finished sector and the start pulse with byte 0 of the next sector can fall in the same cycle. The bench provokes this by streaming two sectors back to back with no idle cycle between them. It then judges `done`, `code_out` and `status` in that cycle against the first sector, and the following report against the second. A start pulse in mid-sector is also driven together with a byte, and the reference model expects the partial data to be dropped and that byte to count as offset 0.

// File: rtl/secc_pkg.sv
`timescale 1ns/1ps
package secc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_ERR = 2'd2,
        ST_UNCORR   = 2'd3
    } secc_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_GATHER = 2'd1,
        S_REPORT = 2'd2
    } secc_state_e;

    // Bits of a byte whose bit index has bit k set
    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((b >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/secc_ctrl.sv
`timescale 1ns/1ps
module secc_ctrl
    import secc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int OFF_W        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_start,
    input  logic             byte_valid,
    input  logic             check_mode,
    output logic             byte_accept,
    output logic             acc_clear,
    output logic [OFF_W-1:0] byte_offset,
    output logic             report,
    output logic             idle,
    output logic             mode_check
);

    localparam int               LAST_I   = SECTOR_BYTES - 1;
    localparam logic [OFF_W-1:0] LAST_OFF = LAST_I[OFF_W-1:0];

    secc_state_e      state_q;
    secc_state_e      state_d;
    logic [OFF_W-1:0] cnt_q;
    logic             mode_q;
    logic             last_byte;

    // Byte acceptance and offset for the parity datapath
    always_comb begin
        byte_accept = byte_valid && (sector_start || (state_q == S_GATHER));
        byte_offset = sector_start ? '0 : cnt_q;
        last_byte   = byte_accept && (byte_offset == LAST_OFF);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (sector_start) state_d = S_GATHER;
            S_GATHER: if (last_byte)    state_d = S_REPORT;
            S_REPORT: state_d = sector_start ? S_GATHER : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (last_byte) begin
            state_d = S_REPORT;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Byte counter and captured mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            if (sector_start) begin
                cnt_q  <= byte_accept ? OFF_W'(1) : '0;
                mode_q <= check_mode;
            end else if (byte_accept) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        report     = (state_q == S_REPORT);
        idle       = (state_q == S_IDLE);
        acc_clear  = sector_start;
        mode_check = mode_q;
    end

endmodule

// File: rtl/secc_accum.sv
`timescale 1ns/1ps
module secc_accum
    import secc_pkg::*;
#(
    parameter int HALF_W = 12,
    parameter int OFF_W  = HALF_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic [OFF_W-1:0]  offset,
    input  logic [7:0]        data,
    output logic [HALF_W-1:0] set_par,
    output logic [HALF_W-1:0] clr_par
);

    logic [HALF_W-1:0] set_c;
    logic [HALF_W-1:0] clr_c;
    logic [HALF_W-1:0] set_q;
    logic [HALF_W-1:0] clr_q;
    logic              dpar;

    assign dpar = ^data;

    // Per position bit: the low three bits select lanes inside the byte,
    // the rest come from the byte offset and see the whole byte's parity.
    for (genvar k = 0; k < HALF_W; k++) begin : g_bit
        if (k < 3) begin : g_lane
            localparam logic [7:0] LMASK = lane_mask(k);
            assign set_c[k] = ^(data & LMASK);
            assign clr_c[k] = ^(data & ~LMASK);
        end else begin : g_off
            assign set_c[k] = dpar &  offset[k-3];
            assign clr_c[k] = dpar & ~offset[k-3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            clr_q <= '0;
        end else if (clear || accept) begin
            set_q <= (clear ? '0 : set_q) ^ (accept ? set_c : '0);
            clr_q <= (clear ? '0 : clr_q) ^ (accept ? clr_c : '0);
        end
    end

    assign set_par = set_q;
    assign clr_par = clr_q;

endmodule

// File: rtl/secc_classify.sv
`timescale 1ns/1ps
module secc_classify
    import secc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int HALF_W       = 12
) (
    input  logic [2*HALF_W-1:0] stored,
    input  logic [2*HALF_W-1:0] computed,
    input  logic                check_en,
    output secc_status_e        status,
    output logic [HALF_W-4:0]   offset,
    output logic [2:0]          bit_idx
);

    localparam int               CODE_W = 2 * HALF_W;
    localparam int               OFF_W  = HALF_W - 3;
    localparam logic [OFF_W:0]   LIMIT  = SECTOR_BYTES[OFF_W:0];

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] fold;
    logic              single;
    logic [OFF_W-1:0]  d_off;
    logic [2:0]        d_bit;

    always_comb begin
        diff   = stored ^ computed;
        fold   = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
        single = (diff != '0) && ((diff & (diff - CODE_W'(1))) == '0);
        d_off  = diff[CODE_W-1 -: OFF_W];
        d_bit  = diff[HALF_W+2:HALF_W];
    end

    always_comb begin
        status  = ST_CLEAN;
        offset  = '0;
        bit_idx = '0;
        if (check_en && (diff != '0)) begin
            if (&fold) begin
                if ({1'b0, d_off} < LIMIT) begin
                    status  = ST_DATA_FIX;
                    offset  = d_off;
                    bit_idx = d_bit;
                end else begin
                    status  = ST_UNCORR;
                end
            end else if (single) begin
                status = ST_CODE_ERR;
            end else begin
                status = ST_UNCORR;
            end
        end
    end

endmodule

// File: rtl/sector_ecc_core.sv
`timescale 1ns/1ps
module sector_ecc_core
    import secc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int HALF_W       = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sector_start,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    input  logic                check_mode,
    input  logic [2*HALF_W-1:0] stored_code,
    output logic [2*HALF_W-1:0] code_out,
    output logic                done,
    output logic [1:0]          status,
    output logic [HALF_W-4:0]   err_offset,
    output logic [2:0]          err_bit
);

    localparam int OFF_W = HALF_W - 3;

    logic              byte_accept;
    logic              acc_clear;
    logic [OFF_W-1:0]  byte_offset;
    logic              report;
    logic              ctrl_idle;
    logic              mode_check;
    logic [HALF_W-1:0] set_par;
    logic [HALF_W-1:0] clr_par;
    logic [2*HALF_W-1:0] code_w;
    secc_status_e      cls_status;
    logic [OFF_W-1:0]  cls_offset;
    logic [2:0]        cls_bit;

    secc_ctrl #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .OFF_W        (OFF_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sector_start (sector_start),
        .byte_valid   (byte_valid),
        .check_mode   (check_mode),
        .byte_accept  (byte_accept),
        .acc_clear    (acc_clear),
        .byte_offset  (byte_offset),
        .report       (report),
        .idle         (ctrl_idle),
        .mode_check   (mode_check)
    );

    secc_accum #(
        .HALF_W (HALF_W),
        .OFF_W  (OFF_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .accept  (byte_accept),
        .offset  (byte_offset),
        .data    (byte_data),
        .set_par (set_par),
        .clr_par (clr_par)
    );

    assign code_w = ~{set_par, clr_par};

    secc_classify #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .HALF_W       (HALF_W)
    ) u_classify (
        .stored   (stored_code),
        .computed (code_w),
        .check_en (mode_check),
        .status   (cls_status),
        .offset   (cls_offset),
        .bit_idx  (cls_bit)
    );

    // Outputs: the result is presented only in the report cycle
    always_comb begin
        code_out   = code_w;
        done       = report;
        status     = ST_CLEAN;
        err_offset = '0;
        err_bit    = '0;
        if (report) begin
            status     = cls_status;
            err_offset = cls_offset;
            err_bit    = cls_bit;
        end
    end

endmodule

// File: rtl/secc_checker.sv
`timescale 1ns/1ps
module secc_checker #(
    parameter int SECTOR_BYTES = 512,
    parameter int HALF_W       = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sector_start,
    input logic [2*HALF_W-1:0] stored_code,
    input logic [2*HALF_W-1:0] code_out,
    input logic                done,
    input logic [1:0]          status,
    input logic [HALF_W-4:0]   err_offset,
    input logic [2:0]          err_bit,
    input logic                byte_accept,
    input logic                ctrl_idle,
    input logic                mode_check
);

    localparam int             OFF_W = HALF_W - 3;
    localparam logic [OFF_W:0] LIMIT = SECTOR_BYTES[OFF_W:0];

    // R3: the report lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a report always follows an accepted byte
    a_r3_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_accept));

    // R5: no start while idle leaves the code untouched
    a_r5_idle_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idle && !sector_start) |=> $stable(code_out));

    // R6: a clean check means the stored and computed codes agree
    a_r6_clean_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_check && status == 2'd0) |-> (stored_code == code_out));

    // R7: fields are zero unless a data fix is reported
    a_r7_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && status == 2'd1) |-> (err_offset == '0 && err_bit == '0));

    // R8: a data fix never points beyond the sector
    a_r8_offset_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> ({1'b0, err_offset} < LIMIT));

    // R9: a code fault differs from the stored code in one bit
    a_r9_code_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> $onehot(stored_code ^ code_out));

    // R11: generate mode always reports clean
    a_r11_generate_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_check) |-> (status == 2'd0));

endmodule

bind sector_ecc_core secc_checker #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .HALF_W       (HALF_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sector_start (sector_start),
    .stored_code  (stored_code),
    .code_out     (code_out),
    .done         (done),
    .status       (status),
    .err_offset   (err_offset),
    .err_bit      (err_bit),
    .byte_accept  (byte_accept),
    .ctrl_idle    (ctrl_idle),
    .mode_check   (mode_check)
);

// File: tb/sector_ecc_core_tb.sv
`timescale 1ns/1ps
module sector_ecc_core_tb;

    localparam int N  = 512;
    localparam int NS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        valid = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        mode = 1'b0;
    logic [23:0] stored = 24'h0;
    logic [23:0] code_out;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  err_offset;
    logic [2:0]  err_bit;

    logic        s_start = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_mode = 1'b0;
    logic [23:0] s_stored = 24'h0;
    logic [23:0] s_code;
    logic        s_done;
    logic [1:0]  s_status;
    logic [8:0]  s_offset;
    logic [2:0]  s_bit;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sector_ecc_core #(.SECTOR_BYTES(N), .HALF_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .sector_start(start), .byte_valid(valid),
        .byte_data(data), .check_mode(mode), .stored_code(stored),
        .code_out(code_out), .done(done), .status(status),
        .err_offset(err_offset), .err_bit(err_bit)
    );

    sector_ecc_core #(.SECTOR_BYTES(NS), .HALF_W(12)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .sector_start(s_start), .byte_valid(s_valid),
        .byte_data(s_data), .check_mode(s_mode), .stored_code(s_stored),
        .code_out(s_code), .done(s_done), .status(s_status),
        .err_offset(s_offset), .err_bit(s_bit)
    );

    // Reference model state
    logic [7:0]  m_buf [N];
    logic [7:0]  pat [N];
    int          m_cnt = 0;
    bit          m_active = 0;
    bit          m_mode = 0;
    bit          exp_done = 0;
    bit          exp_mode = 0;
    logic [23:0] exp_code = 24'hFFFFFF;
    string       cur_tag = "reset";
    logic [31:0] rs = 32'h1234_5678;

    function automatic logic [7:0] rnd8();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs[7:0];
    endfunction

    function automatic logic [23:0] ref_code(input logic [7:0] a [N]);
        logic [11:0] up = '0;
        logic [11:0] lo = '0;
        for (int i = 0; i < N; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (a[i][b]) begin
                    int pos = i * 8 + b;
                    for (int k = 0; k < 12; k++) begin
                        if (((pos >> k) & 1) != 0) up[k] = ~up[k];
                        else                       lo[k] = ~lo[k];
                    end
                end
            end
        end
        return ~{up, lo};
    endfunction

    function automatic void classify_ref(input logic [23:0] st, input logic [23:0] cd,
                                         input bit md, output logic [1:0] s,
                                         output logic [8:0] o, output logic [2:0] b);
        logic [23:0] d;
        d = st ^ cd;
        s = 2'd0; o = 9'd0; b = 3'd0;
        if (md && d != 24'd0) begin
            if ((d[23:12] ^ d[11:0]) == 12'hFFF) begin
                if (int'(d[23:15]) < N) begin
                    s = 2'd1; o = d[23:15]; b = d[14:12];
                end else begin
                    s = 2'd3;
                end
            end else if ($countones(d) == 1) begin
                s = 2'd2;
            end else begin
                s = 2'd3;
            end
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [1:0] es;
        logic [8:0] eo;
        logic [2:0] eb;
        chk({cur_tag, " R3 done"}, {31'd0, done}, {31'd0, exp_done});
        if (exp_done) begin
            chk({cur_tag, " R1 code"}, {8'd0, code_out}, {8'd0, exp_code});
            classify_ref(stored, exp_code, exp_mode, es, eo, eb);
            chk({cur_tag, " status"}, {30'd0, status}, {30'd0, es});
            chk({cur_tag, " R7 offset"}, {23'd0, err_offset}, {23'd0, eo});
            chk({cur_tag, " R7 bit"}, {29'd0, err_bit}, {29'd0, eb});
        end else begin
            chk({cur_tag, " R3 quiet fields"}, {18'd0, status, err_offset, err_bit}, 32'd0);
            if (!m_active) begin
                chk({cur_tag, " R5 code hold"}, {8'd0, code_out}, {8'd0, exp_code});
            end
        end
    endtask

    // One clock: drive at the falling edge, compare at the next falling edge
    task automatic step(input logic st, input logic v, input logic [7:0] d);
        bit acc;
        start = st; valid = v; data = d;
        acc = v && (st || m_active);
        if (st) begin
            m_active = 1; m_cnt = 0; m_mode = mode;
        end
        exp_done = 0;
        if (acc) begin
            m_buf[m_cnt] = d;
            m_cnt++;
            if (m_cnt == N) begin
                m_active = 0;
                exp_done = 1;
                exp_code = ref_code(m_buf);
                exp_mode = m_mode;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run_sector(input string tag, input int gap_every);
        cur_tag = tag;
        step(1'b1, 1'b1, pat[0]);
        for (int i = 1; i < N; i++) begin
            if (gap_every != 0 && (i % gap_every) == 0) begin
                step(1'b0, 1'b0, 8'h5A);
            end
            step(1'b0, 1'b1, pat[i]);
        end
    endtask

    task automatic idle_step();
        step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic small_sector(input int pos, input logic [1:0] es,
                                input logic [8:0] eo, input logic [2:0] eb, input string tag);
        logic [11:0] p;
        p = pos[11:0];
        s_mode = 1'b1;
        s_stored = 24'hFFFFFF ^ {p, ~p};
        for (int i = 0; i < NS; i++) begin
            s_start = (i == 0); s_valid = 1'b1; s_data = 8'h00;
            @(posedge clk);
            @(negedge clk);
        end
        s_start = 1'b0; s_valid = 1'b0;
        chk({tag, " R3 done"}, {31'd0, s_done}, 32'd1);
        chk({tag, " status"}, {30'd0, s_status}, {30'd0, es});
        chk({tag, " R7 offset"}, {23'd0, s_offset}, {23'd0, eo});
        chk({tag, " R7 bit"}, {29'd0, s_bit}, {29'd0, eb});
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] good;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R3: reset state
        chk("R1 reset code", {8'd0, code_out}, 32'h00FFFFFF);
        chk("R3 reset done", {31'd0, done}, 32'd0);

        // R2: erased sector checks clean
        for (int i = 0; i < N; i++) pat[i] = 8'hFF;
        mode = 1'b1; stored = 24'hFFFFFF;
        run_sector("R2 erased", 0);
        idle_step();

        // R11: generate mode ignores stored code
        for (int i = 0; i < N; i++) pat[i] = rnd8();
        good = ref_code(pat);
        mode = 1'b0; stored = 24'h123456;
        run_sector("R11 generate", 0);
        idle_step();

        // R6 with R5 gaps: clean check
        mode = 1'b1; stored = good;
        run_sector("R6 R5 clean gaps", 7);
        idle_step();

        // R5: bytes offered while idle are ignored
        cur_tag = "R5 idle bytes";
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, rnd8());

        // R9: single bit of the code damaged
        stored = good ^ 24'h000080;
        run_sector("R9 code fault", 0);
        idle_step();

        // R10: two code bits damaged
        stored = good ^ 24'h000003;
        run_sector("R10 two code bits", 0);
        idle_step();

        // R7: one data bit flipped at offset 300 bit 5
        stored = good;
        pat[300] = pat[300] ^ 8'h20;
        run_sector("R7 data fix", 0);
        idle_step();

        // R10: two data bits flipped
        pat[17] = pat[17] ^ 8'h01;
        run_sector("R10 two data bits", 0);
        idle_step();
        pat[17] = pat[17] ^ 8'h01;
        pat[300] = pat[300] ^ 8'h20;

        // R4: restart in mid-sector discards the partial data
        cur_tag = "R4 restart";
        step(1'b1, 1'b1, 8'hC3);
        for (int i = 1; i < 100; i++) step(1'b0, 1'b1, rnd8());
        run_sector("R4 restart", 0);
        idle_step();

        // R12: back-to-back sectors, start in the report cycle
        for (int i = 0; i < N; i++) pat[i] = rnd8();
        good = ref_code(pat);
        stored = good;
        run_sector("R12 first", 0);
        run_sector("R12 second", 3);
        idle_step();

        // R8: small sector, fix pattern at or beyond the sector end
        small_sector(255 * 8 + 4, 2'd1, 9'd255, 3'd4, "R8 last byte");
        small_sector(256 * 8 + 0, 2'd3, 9'd0, 3'd0, "R8 first outside");
        small_sector(300 * 8 + 2, 2'd3, 9'd0, 3'd0, "R8 far outside");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule